// File: doc/BRIEF.md
# Two-Level Inclusive Cache Controller

This block places two cache levels between a single processor request port and a main-memory port. The processor issues single-word reads and writes. It hands a request over with a valid/ready handshake and receives a one-cycle response pulse. The first level is small and write-through, and it never holds modified data. The second level is larger and write-back. Each of its lines carries a dirty flag, and modified data reaches memory only when such a line is displaced.

A request looks in level one first and then in level two. Main memory is used only when both levels miss. Level two always contains every line that level one holds. When level two displaces a line, any level-one copy of it is dropped in the same step. Memory answers after a fixed number of cycles set by a parameter. Only one miss is in flight at a time, and the processor port stays stalled until it completes.

Addresses count words. A line holds one word. Level one has `L1_SETS` sets and level two has `L2_SETS` sets, both two-way. A line's set is its address modulo the set count.

Top module: `twolvl_cache`

## Requirements
- R1: After reset, cpu_ready is 1, resp_valid is 0, mem_req is 0 and every counter output is 0.
- R2: A read that hits level one raises resp_valid on the first clock edge after the accepting edge, returns the stored word, and causes no memory access.
- R3: A read that misses level one and hits level two responds on the second edge after acceptance. It installs the line in level one, so an immediate repeat of the read hits level one.
- R4: Every write is applied to level two. If level one holds the line, it is updated too. A write that hits level one responds on the second edge, and a later read hits level one with the new value. Level-one lines are never dirty.
- R5: Writes never reach memory directly. A modified level-two line is written to memory with its latest value only when it is displaced. Displacing a clean line causes no memory write.
- R6: A write miss fetches the line into level two before the write is applied, and it does not install the line in level one. The next read of that address misses level one, hits level two (2 edges), and returns the written value.
- R7: A miss in both levels with a clean or empty victim responds MEM_LAT+3 edges after acceptance and issues one memory read. With a dirty victim it responds after 2*MEM_LAT+3 edges, and the memory write comes before the read.
- R8: Within a set, an empty way is filled first. Otherwise the least recently used of the two ways is replaced. Level-one recency follows level-one hits and fills. Level-two recency follows level-two lookups and fills.
- R9: When level two displaces a line that level one holds, the level-one copy is invalidated. A later read of that address then misses both levels.
- R10: The counter outputs count level-one hits and misses, level-two hits and misses, and level-two writebacks. A second lookup made after a refill is not counted.
- R11: One request is accepted at a time. cpu_ready is low from the accepting edge until the response. resp_valid is a one-cycle pulse issued while cpu_ready is high, and no memory request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | DATA_W | Read data, valid with resp_valid on reads |
| mem_req | output | 1 | One-cycle memory request pulse |
| mem_we | output | 1 | 1 = writeback, 0 = line fetch |
| mem_addr | output | ADDR_W | Memory word address, held for the whole access |
| mem_wdata | output | DATA_W | Writeback data |
| mem_rdata | input | DATA_W | Memory read data, sampled MEM_LAT cycles after the request |
| l1_hits | output | CNT_W | Level-one hit count |
| l1_misses | output | CNT_W | Level-one miss count |
| l2_hits | output | CNT_W | Level-two hit count |
| l2_misses | output | CNT_W | Level-two miss count |
| l2_wbacks | output | CNT_W | Dirty writeback count |

## Verification
The hardest situation to reach from the ports is a back-invalidation that actually matters. The level-two victim must still be live in level one, and level one's own replacement must not have removed it already. The stimulus fills two lines into the same set of both levels. It then re-reads the older line, which is a level-one hit and therefore leaves level-two recency unchanged. A third conflicting read then makes level two evict that line while level-one recency points at the other way. Only a working back-invalidation turns the next read of that line into a full miss with the refill latency. Without it, the read would be a one-edge hit.

// File: rtl/l2inc_pkg.sv
package l2inc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int NWAYS  = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK1, S_LOOK2, S_WB, S_FETCH
    } ctl_state_e;

    typedef struct packed {
        logic  we;
        addr_t addr;
        data_t wdata;
    } cpu_req_t;

    // empty way first, otherwise the way the recency bit points at
    function automatic logic pick_victim(logic v0, logic v1, logic lru);
        if (!v0) return 1'b0;
        if (!v1) return 1'b1;
        return lru;
    endfunction
endpackage

// File: rtl/cache_level.sv
module cache_level
    import l2inc_pkg::*;
#(
    parameter int SETS       = 4,
    parameter bit WRITE_BACK = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t lk_addr,
    output logic  hit,
    output data_t hit_data,
    output logic  vic_valid,
    output logic  vic_dirty,
    output addr_t vic_addr,
    output data_t vic_data,
    input  logic  touch_en,
    input  logic  upd_en,
    input  data_t upd_data,
    input  logic  fill_en,
    input  data_t fill_data,
    input  logic  fill_dirty,
    input  logic  inv_en,
    input  addr_t inv_addr
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0] tag_q   [SETS][NWAYS];
    data_t            data_q  [SETS][NWAYS];
    logic             valid_q [SETS][NWAYS];
    logic             dirty_q [SETS][NWAYS];
    logic             lru_q   [SETS];

    logic [IDX_W-1:0] idx, inv_idx;
    logic [TAG_W-1:0] tg, inv_tg;
    logic [NWAYS-1:0] way_hit, inv_match;
    logic             hit_way, vic_way;

    assign idx     = lk_addr[IDX_W-1:0];
    assign tg      = lk_addr[ADDR_W-1:IDX_W];
    assign inv_idx = inv_addr[IDX_W-1:0];
    assign inv_tg  = inv_addr[ADDR_W-1:IDX_W];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        assign way_hit[w]   = valid_q[idx][w] && (tag_q[idx][w] == tg);
        assign inv_match[w] = valid_q[inv_idx][w] && (tag_q[inv_idx][w] == inv_tg);
    end

    assign hit       = |way_hit;
    assign hit_way   = way_hit[1];
    assign hit_data  = data_q[idx][hit_way];
    assign vic_way   = pick_victim(valid_q[idx][0], valid_q[idx][1], lru_q[idx]);
    assign vic_valid = valid_q[idx][vic_way];
    assign vic_dirty = dirty_q[idx][vic_way];
    assign vic_addr  = {tag_q[idx][vic_way], idx};
    assign vic_data  = data_q[idx][vic_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                lru_q[s] <= 1'b0;
                for (int w = 0; w < NWAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                end
            end
        end else begin
            if (inv_en) begin
                for (int w = 0; w < NWAYS; w++) begin
                    if (inv_match[w]) begin
                        valid_q[inv_idx][w] <= 1'b0;
                        dirty_q[inv_idx][w] <= 1'b0;
                    end
                end
            end
            if (touch_en) lru_q[idx] <= ~hit_way;
            if (upd_en && WRITE_BACK) dirty_q[idx][hit_way] <= 1'b1;
            if (fill_en) begin
                valid_q[idx][vic_way] <= 1'b1;
                dirty_q[idx][vic_way] <= fill_dirty;
                lru_q[idx]            <= ~vic_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en) data_q[idx][hit_way] <= upd_data;
        if (fill_en) begin
            tag_q[idx][vic_way]  <= tg;
            data_q[idx][vic_way] <= fill_data;
        end
    end
endmodule

// File: rtl/twolvl_cache.sv
module twolvl_cache
    import l2inc_pkg::*;
#(
    parameter int L1_SETS = 4,
    parameter int L2_SETS = 8,
    parameter int MEM_LAT = 4,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  l1_hits,
    output logic [CNT_W-1:0]  l1_misses,
    output logic [CNT_W-1:0]  l2_hits,
    output logic [CNT_W-1:0]  l2_misses,
    output logic [CNT_W-1:0]  l2_wbacks
);
    localparam int LAT_W = $clog2(MEM_LAT + 1);

    ctl_state_e       st_q;
    cpu_req_t         req_q;
    logic             retry_q;
    logic [LAT_W-1:0] cnt_q;
    addr_t            vic_addr_q;
    data_t            vic_data_q;
    logic             mem_done;

    logic  l1_hit, l1_vic_valid, l1_vic_dirty;
    data_t l1_data, l1_vic_data;
    addr_t l1_vic_addr;
    logic  l2_hit, l2_vic_valid, l2_vic_dirty;
    data_t l2_data, l2_vic_data;
    addr_t l2_vic_addr;

    logic l1_touch, l1_upd, l1_fill, l1_inv;
    logic l2_touch, l2_upd, l2_fill;

    assign l1_touch = (st_q == S_LOOK1) && l1_hit;
    assign l1_upd   = l1_touch && req_q.we;
    assign l1_fill  = (st_q == S_LOOK2) && l2_hit && !req_q.we;
    assign l1_inv   = (st_q == S_LOOK2) && !l2_hit && l2_vic_valid;
    assign l2_touch = (st_q == S_LOOK2) && l2_hit;
    assign l2_upd   = l2_touch && req_q.we;
    assign mem_done = (cnt_q == LAT_W'(MEM_LAT - 1));
    assign l2_fill  = (st_q == S_FETCH) && mem_done;

    cache_level #(.SETS(L1_SETS), .WRITE_BACK(1'b0)) u_l1 (
        .clk(clk), .rst(rst), .lk_addr(req_q.addr),
        .hit(l1_hit), .hit_data(l1_data),
        .vic_valid(l1_vic_valid), .vic_dirty(l1_vic_dirty),
        .vic_addr(l1_vic_addr), .vic_data(l1_vic_data),
        .touch_en(l1_touch), .upd_en(l1_upd), .upd_data(req_q.wdata),
        .fill_en(l1_fill), .fill_data(l2_data), .fill_dirty(1'b0),
        .inv_en(l1_inv), .inv_addr(l2_vic_addr)
    );

    cache_level #(.SETS(L2_SETS), .WRITE_BACK(1'b1)) u_l2 (
        .clk(clk), .rst(rst), .lk_addr(req_q.addr),
        .hit(l2_hit), .hit_data(l2_data),
        .vic_valid(l2_vic_valid), .vic_dirty(l2_vic_dirty),
        .vic_addr(l2_vic_addr), .vic_data(l2_vic_data),
        .touch_en(l2_touch), .upd_en(l2_upd), .upd_data(req_q.wdata),
        .fill_en(l2_fill), .fill_data(mem_rdata), .fill_dirty(1'b0),
        .inv_en(1'b0), .inv_addr('0)
    );

    assign cpu_ready = (st_q == S_IDLE);
    assign mem_req   = ((st_q == S_WB) || (st_q == S_FETCH)) && (cnt_q == '0);
    assign mem_we    = (st_q == S_WB);
    assign mem_addr  = (st_q == S_WB) ? vic_addr_q : req_q.addr;
    assign mem_wdata = vic_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            req_q      <= '0;
            retry_q    <= 1'b0;
            cnt_q      <= '0;
            vic_addr_q <= '0;
            vic_data_q <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            l1_hits    <= '0;
            l1_misses  <= '0;
            l2_hits    <= '0;
            l2_misses  <= '0;
            l2_wbacks  <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (st_q)
                S_IDLE: if (cpu_valid) begin
                    req_q <= '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
                    st_q  <= S_LOOK1;
                end
                S_LOOK1: begin
                    retry_q <= 1'b0;
                    if (l1_hit) l1_hits <= l1_hits + 1'b1;
                    else        l1_misses <= l1_misses + 1'b1;
                    if (l1_hit && !req_q.we) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= l1_data;
                        st_q       <= S_IDLE;
                    end else begin
                        st_q <= S_LOOK2;
                    end
                end
                S_LOOK2: begin
                    if (l2_hit) begin
                        if (!retry_q) l2_hits <= l2_hits + 1'b1;
                        resp_valid <= 1'b1;
                        if (!req_q.we) resp_rdata <= l2_data;
                        st_q <= S_IDLE;
                    end else begin
                        l2_misses  <= l2_misses + 1'b1;
                        vic_addr_q <= l2_vic_addr;
                        vic_data_q <= l2_vic_data;
                        cnt_q      <= '0;
                        if (l2_vic_valid && l2_vic_dirty) begin
                            l2_wbacks <= l2_wbacks + 1'b1;
                            st_q      <= S_WB;
                        end else begin
                            st_q <= S_FETCH;
                        end
                    end
                end
                S_WB: begin
                    if (mem_done) begin
                        cnt_q <= '0;
                        st_q  <= S_FETCH;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_FETCH: begin
                    if (mem_done) begin
                        cnt_q   <= '0;
                        retry_q <= 1'b1;
                        st_q    <= S_LOOK2;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/twolvl_cache_checker.sv
module twolvl_cache_checker
    import l2inc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input ctl_state_e st,
    input logic       cpu_ready,
    input logic       resp_valid,
    input logic       mem_req,
    input logic       mem_we,
    input logic       req_we,
    input addr_t      req_addr,
    input logic       l1_hit,
    input logic       l2_hit,
    input data_t      l1_data,
    input data_t      l2_data,
    input logic       l1_vic_valid,
    input logic       l1_vic_dirty,
    input addr_t      l1_vic_addr,
    input data_t      l1_vic_data
);
    a_r11_resp_while_ready: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> cpu_ready);
    a_r11_resp_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
    a_r11_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req);
    a_r5_wb_after_lookup: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ($past(st) == S_LOOK2));
    a_r7_fetch_order: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> ($past(st) == S_LOOK2 || $past(st) == S_WB));
    a_r9_inclusive: assert property (@(posedge clk) disable iff (rst)
        ((st == S_LOOK1 || st == S_LOOK2) && l1_hit) |-> l2_hit);
    a_r4_copies_match: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOOK1 && l1_hit) |-> (l1_data == l2_data));
    a_r4_l1_clean: assert property (@(posedge clk) disable iff (rst)
        !(l1_vic_valid && l1_vic_dirty));
    a_r3_fill_keeps_target: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOOK2 && l2_hit && !req_we && l1_vic_valid)
            |-> (l1_vic_addr != req_addr || l1_vic_data == l2_data));
endmodule

bind twolvl_cache twolvl_cache_checker u_chk (
    .clk(clk), .rst(rst), .st(st_q), .cpu_ready(cpu_ready),
    .resp_valid(resp_valid), .mem_req(mem_req), .mem_we(mem_we),
    .req_we(req_q.we), .req_addr(req_q.addr),
    .l1_hit(l1_hit), .l2_hit(l2_hit), .l1_data(l1_data), .l2_data(l2_data),
    .l1_vic_valid(l1_vic_valid), .l1_vic_dirty(l1_vic_dirty),
    .l1_vic_addr(l1_vic_addr), .l1_vic_data(l1_vic_data)
);

// File: tb/twolvl_cache_test.sv
module twolvl_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam int MISS_LAT   = LAT + 3;
    localparam int DIRTY_LAT  = 2 * LAT + 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready, resp_valid, mem_req, mem_we;
    logic [15:0] resp_rdata, mem_wdata, mem_rdata;
    logic [7:0]  mem_addr;
    logic [15:0] l1_hits, l1_misses, l2_hits, l2_misses, l2_wbacks;

    logic [15:0] mem [256];
    logic [15:0] shadow [256];
    int mem_wr_n = 0, mem_rd_n = 0;
    int checks = 0, errors = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twolvl_cache #(.L1_SETS(4), .L2_SETS(8), .MEM_LAT(LAT), .CNT_W(16)) uut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .l1_hits(l1_hits), .l1_misses(l1_misses), .l2_hits(l2_hits),
        .l2_misses(l2_misses), .l2_wbacks(l2_wbacks)
    );

    function automatic logic [15:0] init_val(int a);
        return 16'(16'h1000 + a * 3);
    endfunction

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                mem_wr_n <= mem_wr_n + 1;
            end else begin
                mem_rd_n <= mem_rd_n + 1;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [7:0] a, input logic [15:0] d,
                          output int lat, output logic [15:0] rd, output logic busy_ok);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (we) shadow[a] = d;
        @(negedge clk);
        cpu_valid = 1'b0;
        busy_ok = !cpu_ready;
        lat = 0;
        while (!resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rd = resp_rdata;
    endtask

    task automatic rd_expect(input logic [7:0] a, input int exp_lat, input string req);
        int lat; logic [15:0] rd; logic b;
        access(1'b0, a, '0, lat, rd, b);
        check(lat == exp_lat, req, "read latency", lat, exp_lat);
        check(rd == shadow[a], req, "read data", rd, shadow[a]);
    endtask

    task automatic wr_expect(input logic [7:0] a, input logic [15:0] d,
                             input int exp_lat, input string req);
        int lat; logic [15:0] rd; logic b;
        access(1'b1, a, d, lat, rd, b);
        check(lat == exp_lat, req, "write latency", lat, exp_lat);
    endtask

    task automatic t_reset;
        check(cpu_ready == 1'b1, "R1", "cpu_ready", cpu_ready, 1);
        check(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
        check(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
        check((l1_hits | l1_misses | l2_hits | l2_misses | l2_wbacks) == 0,
              "R1", "counters", l1_hits | l1_misses | l2_hits | l2_misses | l2_wbacks, 0);
    endtask

    task automatic t_cold_and_hit;
        int lat; logic [15:0] rd; logic busy;
        access(1'b0, 8'h10, '0, lat, rd, busy);
        check(busy, "R11", "cpu_ready low while busy", !busy, 0);
        check(lat == MISS_LAT, "R7", "clean miss latency", lat, MISS_LAT);
        check(rd == shadow[8'h10], "R7", "miss data", rd, shadow[8'h10]);
        check(mem_rd_n == 1 && mem_wr_n == 0, "R7", "one fetch, no write", mem_rd_n, 1);
        rd_expect(8'h10, 1, "R2");
        check(mem_rd_n == 1, "R2", "hit makes no memory access", mem_rd_n, 1);
    endtask

    task automatic t_write_through;
        wr_expect(8'h10, 16'hBEEF, 2, "R4");
        check(mem_wr_n == 0, "R5", "write kept out of memory", mem_wr_n, 0);
        check(mem[8'h10] == init_val(8'h10), "R5", "memory word untouched",
              mem[8'h10], init_val(8'h10));
        rd_expect(8'h10, 1, "R4");
    endtask

    task automatic t_write_allocate;
        wr_expect(8'h25, 16'h5A5A, MISS_LAT, "R6");
        check(mem_rd_n == 2, "R6", "write miss fetched line", mem_rd_n, 2);
        rd_expect(8'h25, 2, "R6");
        rd_expect(8'h25, 1, "R3");
        check(mem_wr_n == 0, "R5", "no write before eviction", mem_wr_n, 0);
    endtask

    task automatic t_back_invalidate;
        rd_expect(8'h18, MISS_LAT, "R8");
        rd_expect(8'h10, 1, "R8");
        rd_expect(8'h20, DIRTY_LAT, "R7");
        check(mem_wr_n == 1, "R5", "dirty victim written once", mem_wr_n, 1);
        check(mem[8'h10] == 16'hBEEF, "R5", "writeback data", mem[8'h10], 16'hBEEF);
        rd_expect(8'h10, MISS_LAT, "R9");
        check(mem_wr_n == 1, "R5", "clean victim not written", mem_wr_n, 1);
    endtask

    task automatic t_second_eviction;
        int bad;
        rd_expect(8'h2D, MISS_LAT, "R8");
        rd_expect(8'h35, DIRTY_LAT, "R8");
        check(mem[8'h25] == 16'h5A5A, "R5", "second writeback data", mem[8'h25], 16'h5A5A);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != shadow[i]) bad++;
        check(bad == 0, "R5", "memory matches reference", bad, 0);
    endtask

    task automatic t_counters;
        check(l1_hits == 5, "R10", "l1 hits", l1_hits, 5);
        check(l1_misses == 8, "R10", "l1 misses", l1_misses, 8);
        check(l2_hits == 2, "R10", "l2 hits", l2_hits, 2);
        check(l2_misses == 7, "R10", "l2 misses", l2_misses, 7);
        check(l2_wbacks == 2, "R10", "writebacks", l2_wbacks, 2);
        check(mem_rd_n == 7, "R7", "total fetches", mem_rd_n, 7);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cold_and_hit();
        t_write_through();
        t_write_allocate();
        t_back_invalidate();
        t_second_eviction();
        t_counters();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule